// File: doc/BRIEF.md
# Dense 12-bit Sample Lane Framer

This block sits in front of a link's 8b/10b encoders and turns a stream of 12-bit converter samples into lane octets without wasting the four spare bits that a 16-bit container would carry. One channel's frame is twenty samples. The framer gathers all twenty through a valid/ready input handshake. It then splits them across four lanes, five consecutive samples per lane, and packs each group of five back to back into a 64-bit word. The four leftover low bits of that word are zero.

Each lane word leaves as eight octets, most significant first, one octet per lane per output transfer. All four lanes step together under a single valid/ready output handshake. The line rate per lane is therefore the frame rate times eight octets times ten line bits; at a 150 MHz frame rate that is 12 Gbps.

A start flag marks the first octet of every frame. An end flag marks the final octet of the last frame in each multiframe of K frames. While one frame is being sent, the next one can already be collected, so frames can follow each other with no idle beat.

Top module: `lane_pack_framer`

## Requirements
- R1: After reset, in_ready is 1 and out_valid, out_sof and out_mf_end are 0.
- R2: A sample is captured only on a cycle where in_valid and in_ready are both 1. With out_ready held at 0, exactly 40 samples are taken: one frame waiting in the output stage and one in the input buffer. After that, in_ready stays 0.
- R3: No octet of a frame is offered on the outputs until all 20 of that frame's samples have been captured.
- R4: Lane n (n = 0..3, carried on out_octets[8n+7:8n]) carries samples 5n to 5n+4 of its frame, in that order.
- R5: Within a lane, octet 0 is s0[11:4], octet 1 is {s0[3:0], s1[11:8]}, octet 2 is s1[7:0], and so on through the five samples. Octet 7 is {s4[3:0], 4'b0000}, where s0..s4 are that lane's samples.
- R6: The four pad bits (octet 7, bits [3:0], on every lane) are 0 for any sample data, including all-ones samples.
- R7: Each frame takes exactly 8 output transfers. While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_octets does not change.
- R8: out_sof is 1 on octet 0 of every frame and 0 on every other octet.
- R9: out_mf_end is 1 only on octet 7 of frames K-1, 2K-1, and so on, counting frames from 0 after reset.
- R10: When the next frame is already complete, its octet 0 is offered in the cycle right after the transfer of the previous frame's octet 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Input buffer can take a sample |
| in_sample | input | SMP_W (12) | Converter sample |
| out_ready | input | 1 | Downstream takes the current octets |
| out_valid | output | 1 | Lane octets are valid |
| out_octets | output | LANES*8 (32) | One octet per lane; lane n in bits [8n+7:8n] |
| out_sof | output | 1 | First octet of a frame |
| out_mf_end | output | 1 | Last octet of the last frame of a multiframe |

## Verification
The assertions assume that out_ready is a free choice of the receiver each cycle and that in_sample needs to be meaningful only when in_valid is 1. They do not require a source to hold its data while it is stalled, because a sample is taken only on the accepting edge. The stimulus therefore changes in_sample, in_valid and out_ready freely on every cycle. It uses random throttling on both sides, one long output stall that fills both storage stages, and all-ones samples that push on the pad bits. The multiframe length is set to 4 so that several multiframe boundaries fall inside the run.

// File: rtl/lpf_pkg.sv
package lpf_pkg;
  localparam int OCTET_W = 8;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_SEND = 1'b1
  } seq_state_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lpf_collector.sv
module lpf_collector #(
  parameter int SMP_W = 12,
  parameter int N_SMP = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [SMP_W-1:0]        in_sample,
  input  logic                    load,
  output logic                    frame_valid,
  output logic [N_SMP*SMP_W-1:0]  frame_bus
);
  localparam int CNT_W = $clog2(N_SMP + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(N_SMP);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(N_SMP - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SMP_W-1:0] buf_q [N_SMP];
  logic [SMP_W-1:0] buf_d [N_SMP];
  logic             take;

  assign frame_valid = (cnt_q == FULL_CNT);
  assign in_ready    = !frame_valid;
  assign take        = in_valid && in_ready;

  always_comb begin
    cnt_d = cnt_q;
    buf_d = buf_q;
    if (load) begin
      cnt_d = '0;
    end else if (take) begin
      buf_d[cnt_q] = in_sample;
      cnt_d        = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // Storage has no reset; its clock enable is written out.
  always_ff @(posedge clk) begin
    if (take) begin
      buf_q <= buf_d;
    end
  end

  // Sample 0 sits at the most significant end of the flattened frame.
  for (genvar i = 0; i < N_SMP; i++) begin : g_flat
    assign frame_bus[(N_SMP-1-i)*SMP_W +: SMP_W] = buf_q[i];
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cnt_q == LAST_CNT) |=> frame_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !load) |=> (frame_valid && $stable(frame_bus)));

  p_load_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> frame_valid);
endmodule

// File: rtl/lpf_packer.sv
module lpf_packer #(
  parameter int SMP_W   = 12,
  parameter int SPL     = 5,
  parameter int LANES   = 4,
  parameter int LANE_W  = 64
) (
  input  logic [SPL*LANES*SMP_W-1:0] frame_bus,
  output logic [LANES*LANE_W-1:0]    lane_words
);
  localparam int N_SMP   = SPL * LANES;
  localparam int PAYLOAD = SPL * SMP_W;
  localparam int PAD     = LANE_W - PAYLOAD;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [PAYLOAD-1:0] payload;
    assign payload = frame_bus[(N_SMP - SPL*(l+1))*SMP_W +: PAYLOAD];
    if (PAD > 0) begin : g_pad
      assign lane_words[l*LANE_W +: LANE_W] = {payload, {PAD{1'b0}}};
    end else begin : g_nopad
      assign lane_words[l*LANE_W +: LANE_W] = payload;
    end
  end
endmodule

// File: rtl/lpf_sequencer.sv
module lpf_sequencer
  import lpf_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int LANE_W   = 64,
  parameter int K_FRAMES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_valid,
  input  logic [LANES*LANE_W-1:0]       lane_words,
  output logic                          load,
  input  logic                          out_ready,
  output logic                          out_valid,
  output logic [LANES*OCTET_W-1:0]      out_octets,
  output logic                          out_sof,
  output logic                          out_mf_end
);
  localparam int N_OCT = LANE_W / OCTET_W;
  localparam int IDX_W = idx_width(N_OCT);
  localparam int FRM_W = idx_width(K_FRAMES);
  localparam int PAD   = LANE_W - ((LANE_W / OCTET_W) * OCTET_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_OCT - 1);
  localparam logic [FRM_W-1:0] LAST_FRM = FRM_W'(K_FRAMES - 1);

  seq_state_t               st_q, st_d;
  logic [IDX_W-1:0]         idx_q, idx_d;
  logic [FRM_W-1:0]         frm_q, frm_d;
  logic [LANES*LANE_W-1:0]  word_q;
  logic                     xfer, last_xfer;

  assign out_valid = (st_q == SEQ_SEND);
  assign xfer      = out_valid && out_ready;
  assign last_xfer = xfer && (idx_q == LAST_IDX);
  assign load      = frame_valid && (!out_valid || last_xfer);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    frm_d = frm_q;
    if (last_xfer) begin
      frm_d = (frm_q == LAST_FRM) ? '0 : frm_q + 1'b1;
    end
    if (load) begin
      st_d  = SEQ_SEND;
      idx_d = '0;
    end else if (last_xfer) begin
      st_d  = SEQ_IDLE;
      idx_d = '0;
    end else if (xfer) begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      idx_q <= '0;
      frm_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      frm_q <= frm_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      word_q <= lane_words;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_oct
    logic [LANE_W-1:0] shifted;
    assign shifted = word_q[l*LANE_W +: LANE_W] << (OCTET_W * idx_q);
    assign out_octets[l*OCTET_W +: OCTET_W] = shifted[LANE_W-1 -: OCTET_W];
  end

  assign out_sof    = out_valid && (idx_q == '0);
  assign out_mf_end = out_valid && (idx_q == LAST_IDX) && (frm_q == LAST_FRM);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_octets) && $stable(idx_q)));

  p_next_sof_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (last_xfer && frame_valid) |=> (out_valid && out_sof));

  p_mf_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && out_mf_end) |=> (frm_q == '0));

  p_sof_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && out_sof && !last_xfer) |=> (out_valid && !out_sof));

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    localparam int PB = 64 - 5 * 12;  // pad width of the default lane layout
    if (PAD == 0 && LANE_W == 64) begin : g_padchk
      p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && idx_q == LAST_IDX) |-> (out_octets[l*OCTET_W +: PB] == '0));
    end
  end
endmodule

// File: rtl/lane_pack_framer.sv
module lane_pack_framer #(
  parameter int SMP_W        = 12,
  parameter int SMP_PER_LANE = 5,
  parameter int LANES        = 4,
  parameter int K_FRAMES     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SMP_W-1:0]     in_sample,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [LANES*8-1:0]   out_octets,
  output logic                 out_sof,
  output logic                 out_mf_end
);
  localparam int N_SMP   = SMP_PER_LANE * LANES;
  localparam int PAYLOAD = SMP_PER_LANE * SMP_W;
  localparam int LANE_W  = ((PAYLOAD + 7) / 8) * 8;

  logic [1:0]                  rst_sync_q;
  logic                        rst_int_n;
  logic                        load, frame_valid;
  logic [N_SMP*SMP_W-1:0]      frame_bus;
  logic [LANES*LANE_W-1:0]     lane_words;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  lpf_collector #(.SMP_W(SMP_W), .N_SMP(N_SMP)) u_collect (
    .clk(clk), .rst_n(rst_int_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .load(load), .frame_valid(frame_valid),
    .frame_bus(frame_bus)
  );

  lpf_packer #(.SMP_W(SMP_W), .SPL(SMP_PER_LANE), .LANES(LANES),
               .LANE_W(LANE_W)) u_pack (
    .frame_bus(frame_bus), .lane_words(lane_words)
  );

  lpf_sequencer #(.LANES(LANES), .LANE_W(LANE_W), .K_FRAMES(K_FRAMES)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .frame_valid(frame_valid),
    .lane_words(lane_words), .load(load), .out_ready(out_ready),
    .out_valid(out_valid), .out_octets(out_octets), .out_sof(out_sof),
    .out_mf_end(out_mf_end)
  );

  p_idle_reset_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (in_ready && !out_valid));
endmodule

// File: tb/tb_lane_pack_framer.sv
module tb_lane_pack_framer;
  localparam int K = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_sample = '0;
  logic        out_ready = 1'b0;
  logic        out_valid;
  logic [31:0] out_octets;
  logic        out_sof;
  logic        out_mf_end;

  lane_pack_framer #(.SMP_W(12), .SMP_PER_LANE(5), .LANES(4), .K_FRAMES(K)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_ready(out_ready), .out_valid(out_valid),
    .out_octets(out_octets), .out_sof(out_sof), .out_mf_end(out_mf_end)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    logic [31:0] oct;
    bit          sof;
    bit          mf;
    int          idx;
  } beat_t;

  beat_t       exp_q[$];
  int          smp_q[$];
  int          frame_no = 0;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  int          accepted = 0;
  bit          prev_stall = 0;
  logic [31:0] prev_oct = '0;
  bit          done = 0;

  bit          dv = 0;
  bit          dr = 0;
  logic [11:0] ds = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic build_frame();
    logic [63:0] w [4];
    for (int l = 0; l < 4; l++) begin
      w[l] = '0;
      for (int s = 0; s < 5; s++) w[l] = (w[l] << 12) | 64'(smp_q[5*l + s]);
      w[l] = w[l] << 4;
    end
    for (int k = 0; k < 8; k++) begin
      beat_t b;
      b.oct = '0;
      for (int l = 0; l < 4; l++) b.oct[8*l +: 8] = 8'((w[l] >> (56 - 8*k)) & 64'hFF);
      b.sof = (k == 0);
      b.mf  = (k == 7) && ((frame_no % K) == K - 1);
      b.idx = k;
      exp_q.push_back(b);
    end
    frame_no++;
    smp_q.delete();
  endtask

  task automatic monitor();
    if (prev_stall)
      chk(out_valid === 1'b1 && out_octets === prev_oct, "R7", "stalled octets changed",
          out_octets, prev_oct);
    if (in_valid && in_ready) begin
      smp_q.push_back(int'(in_sample));
      accepted++;
      if (smp_q.size() == 20) build_frame();
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "octet offered before frame complete", out_octets, '0);
      end else begin
        beat_t b;
        b = exp_q.pop_front();
        chk(out_octets === b.oct, "R4 R5", "lane octets", out_octets, b.oct);
        chk(out_sof === b.sof, "R8", "start flag", 32'(out_sof), 32'(b.sof));
        chk(out_mf_end === b.mf, "R9", "multiframe end", 32'(out_mf_end), 32'(b.mf));
        if (b.idx == 7)
          chk((out_octets & 32'h0F0F0F0F) == '0, "R6", "pad bits",
              out_octets & 32'h0F0F0F0F, '0);
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_oct   = out_octets;
  endtask

  task automatic step();
    @(negedge clk);
    in_valid  = dv;
    in_sample = ds;
    out_ready = dr;
    #1;
    monitor();
    cyc++;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int run, cnt0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();
    // R1 reset state
    chk(in_ready === 1'b1, "R1", "in_ready after reset", 32'(in_ready), 1);
    chk(out_valid === 1'b0 && out_sof === 1'b0 && out_mf_end === 1'b0, "R1",
        "outputs after reset", {29'd0, out_valid, out_sof, out_mf_end}, 0);

    // R6: all-ones samples, receiver always ready
    dv = 1; dr = 1; ds = 12'hFFF;
    cnt0 = accepted;
    while (accepted - cnt0 < 20) step();
    dv = 0;
    repeat (20) step();

    // R2: long output stall fills both stages
    dr = 0; dv = 1;
    cnt0 = accepted;
    for (int i = 0; i < 60; i++) begin
      ds = 12'(i * 37 + 5);
      step();
    end
    chk(accepted - cnt0 == 40, "R2", "samples taken under stall", 32'(accepted - cnt0), 40);
    chk(in_ready === 1'b0, "R2", "in_ready while both stages full", 32'(in_ready), 0);

    // R10: release, two frames back to back
    dv = 0; dr = 1;
    run = 0;
    for (int i = 0; i < 16; i++) begin
      step();
      if (out_valid) run++;
      if (i == 8) chk(out_sof === 1'b1, "R10", "next frame octet 0 right after octet 7",
                      32'(out_sof), 1);
    end
    chk(run == 16, "R10", "consecutive beats for two frames", 32'(run), 16);
    step();
    chk(out_valid === 1'b0, "R7", "valid drops after 16 beats", 32'(out_valid), 0);

    // Random throttling and data
    for (int i = 0; i < 2500; i++) begin
      dv = ($urandom % 4) != 0;
      dr = ($urandom % 3) != 0;
      ds = 12'($urandom);
      step();
    end
    dv = 0; dr = 1;
    repeat (40) step();
    chk(exp_q.size() == 0, "R3", "frames left undelivered", 32'(exp_q.size()), 0);
    chk(frame_no > 2 * K, "R9", "frames crossed multiframe bounds", 32'(frame_no), 32'(2 * K + 1));

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule